// File: doc/BRIEF.md
# Key-Locked Watchdog Timer

This block is a watchdog timer that is armed the moment reset is released. A free-running up-counter on a separate functional clock starts at a reload value. When it passes its all-ones value while the watchdog is enabled, it emits a one-cycle system reset request and starts again from the reload value. Software cannot stop it with a single write. It must write an ordered pair of 16-bit keys to a control register: 0xAAAA and then 0x5555 stop the counter. A second ordered pair, 0xBBBB and then 0x4444, restarts it.

Each write to the control register crosses from the bus clock into the functional clock through a toggle handshake. A pending flag in a status register stays set from the bus write until the acknowledgement has come back. Software polls that flag after each key before it writes the next one. The register interface is a plain single-cycle bus with address, write data, write enable and combinational read data.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the watchdog is enabled and the counter holds RELOAD. With no writes, rst_req_o pulses once every 2^CNT_W - RELOAD functional-clock cycles, which is 256 cycles with the default parameters.
- R2: Each reset request lasts exactly one functional-clock cycle. RELOAD must be below the all-ones counter value.
- R3: Writing 0xAAAA and then 0x5555 (compared on bits 15:0) to the control register at offset 0x48 disables the watchdog, and no further reset request is issued. The counter holds its value while disabled.
- R4: After a first key (0xAAAA or 0xBBBB), any other value written next returns the sequencer to idle and leaves the enable state unchanged.
- R5: A second key (0x5555 or 0x4444) written while the sequencer is idle has no effect.
- R6: Writing 0xBBBB and then 0x4444 enables the watchdog and reloads the counter with RELOAD.
- R7: Bit 4 of the status register at offset 0x34 reads 1 from the cycle after an accepted control write until that key has been applied in the functional domain, and reads 0 otherwise.
- R8: A control write made while bit 4 of the status register is 1 is dropped. It changes neither the stored key nor the sequencer.
- R9: Reading offset 0x48 returns the last accepted key in bits 15:0 with zeros above. It reads 0 after reset.
- R10: Reads of any offset other than 0x48 and 0x34 return 0. Writes to any offset other than 0x48, including the read-only status offset, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both clock domains |
| wdt_clk_i | input | 1 | Functional counter clock |
| addr_i | input | AW (8) | Register byte offset |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Single-cycle write strobe |
| rdata_o | output | 32 | Combinational read data for addr_i |
| rst_req_o | output | 1 | One-cycle system reset request, in the functional clock domain |

## Verification
The embedded assertions check the following on every cycle:
- a reset request lasts one cycle;
- a reset request only follows an enabled cycle;
- the enable bit only falls from the stop-waiting state and only rises from the start-waiting state;
- an accepted control write raises the pending flag;
- a control write during pending leaves the stored key unchanged.

Only the bench scenarios can show the following:
- the exact interval between reset requests;
- the end-to-end effect of correct, reversed and interrupted key pairs;
- that an ignored write at an unmapped offset really leaves a half-entered sequence intact;
- that the pending flag clears within a bounded number of bus cycles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE       = 2'd0,
    SEQ_WAIT_STOP  = 2'd1,
    SEQ_WAIT_START = 2'd2
  } seq_state_e;

  localparam int unsigned KEY_W = 16;
  localparam logic [KEY_W-1:0] KEY_STOP_1  = 16'hAAAA;
  localparam logic [KEY_W-1:0] KEY_STOP_2  = 16'h5555;
  localparam logic [KEY_W-1:0] KEY_START_1 = 16'hBBBB;
  localparam logic [KEY_W-1:0] KEY_START_2 = 16'h4444;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= '0;
      else         stg_q[g] <= stg_q[g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wdt_bus_regs.sv
module wdt_bus_regs #(
  parameter int unsigned  AW          = 8,
  parameter int unsigned  DW          = 32,
  parameter int unsigned  KW          = 16,
  parameter logic [AW-1:0] CTRL_OFS   = 8'h48,
  parameter logic [AW-1:0] STAT_OFS   = 8'h34,
  parameter int unsigned  PEND_BIT    = 4,
  parameter int unsigned  SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          we_i,
  output logic [DW-1:0] rdata_o,
  output logic [KW-1:0] key_o,
  output logic          req_tgl_o,
  input  logic          ack_tgl_i
);
  logic [KW-1:0] key_q;
  logic          req_tgl_q;
  logic          ack_s;
  logic          pending;
  logic          ctrl_wr;
  logic          accept;
  logic          unused_wdata;

  assign unused_wdata = ^wdata_i[DW-1:KW];

  wdt_sync #(.STAGES(SYNC_STAGES), .W(1)) u_ack_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_tgl_i),
    .q_o   (ack_s)
  );

  assign pending = req_tgl_q ^ ack_s;
  assign ctrl_wr = we_i && (addr_i == CTRL_OFS);
  assign accept  = ctrl_wr && !pending;  // writes during sync are dropped

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q     <= '0;
      req_tgl_q <= 1'b0;
    end else if (accept) begin
      key_q     <= wdata_i[KW-1:0];
      req_tgl_q <= ~req_tgl_q;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_OFS)      rdata_o[KW-1:0] = key_q;
    else if (addr_i == STAT_OFS) rdata_o[PEND_BIT] = pending;
  end

  assign key_o     = key_q;
  assign req_tgl_o = req_tgl_q;

  // R7: accepted write is visible as pending on the next cycle
  p_pend_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> pending);

  // R8: a write during pending leaves the key untouched
  p_drop_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && pending) |=> $stable(key_q));
endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
#(
  parameter int unsigned KW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_tgl_i,
  input  logic [KW-1:0] key_i,
  output logic          ack_tgl_o,
  output logic          enable_o,
  output logic          reload_o
);
  seq_state_e state_q;
  logic       req_s;
  logic       seen_q;
  logic       apply;
  logic       enable_q;
  logic       reload_q;

  wdt_sync #(.STAGES(SYNC_STAGES), .W(1)) u_req_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (req_tgl_i),
    .q_o   (req_s)
  );

  assign apply = req_s ^ seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SEQ_IDLE;
      seen_q   <= 1'b0;
      enable_q <= 1'b1;  // armed out of reset
      reload_q <= 1'b0;
    end else begin
      reload_q <= 1'b0;
      if (apply) begin
        seen_q <= req_s;
        unique case (state_q)
          SEQ_WAIT_STOP: begin
            state_q <= SEQ_IDLE;
            if (key_i == KEY_STOP_2) enable_q <= 1'b0;
          end
          SEQ_WAIT_START: begin
            state_q <= SEQ_IDLE;
            if (key_i == KEY_START_2) begin
              enable_q <= 1'b1;
              reload_q <= 1'b1;
            end
          end
          default: begin
            if (key_i == KEY_STOP_1)       state_q <= SEQ_WAIT_STOP;
            else if (key_i == KEY_START_1) state_q <= SEQ_WAIT_START;
            else                           state_q <= SEQ_IDLE;
          end
        endcase
      end
    end
  end

  assign ack_tgl_o = seen_q;
  assign enable_o  = enable_q;
  assign reload_o  = reload_q;

  // R3: disable only completes from the stop-waiting state
  p_stop_order_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(enable_q) |-> $past(state_q) == SEQ_WAIT_STOP);

  // R6: enable only completes from the start-waiting state
  p_start_order_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enable_q) |-> $past(state_q) == SEQ_WAIT_START);

  // R4: sequencer moves only on an applied key
  p_step_on_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !apply |=> $stable(state_q));
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned     CNT_W  = 16,
  parameter logic [CNT_W-1:0] RELOAD = 16'hFF00
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic enable_i,
  input  logic reload_i,
  output logic rst_req_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= RELOAD;
      req_q <= 1'b0;
    end else if (reload_i) begin
      cnt_q <= RELOAD;
      req_q <= 1'b0;
    end else if (enable_i) begin
      if (&cnt_q) begin
        cnt_q <= RELOAD;
        req_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
        req_q <= 1'b0;
      end
    end else begin
      req_q <= 1'b0;
    end
  end

  assign rst_req_o = req_q;

  p_req_one_cycle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> !req_q);

  p_req_needs_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> $past(enable_i));
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top #(
  parameter int unsigned      AW          = 8,
  parameter int unsigned      CNT_W       = 16,
  parameter logic [CNT_W-1:0] RELOAD      = 16'hFF00,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wdt_clk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic          we_i,
  output logic [31:0]   rdata_o,
  output logic          rst_req_o
);
  localparam int unsigned   KW       = wdt_pkg::KEY_W;
  localparam logic [AW-1:0] CTRL_OFS = AW'('h48);
  localparam logic [AW-1:0] STAT_OFS = AW'('h34);
  localparam int unsigned   PEND_BIT = 4;

  logic [KW-1:0] key;
  logic          req_tgl;
  logic          ack_tgl;
  logic          enable;
  logic          reload;

  wdt_bus_regs #(
    .AW(AW), .DW(32), .KW(KW), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS),
    .PEND_BIT(PEND_BIT), .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .we_i     (we_i),
    .rdata_o  (rdata_o),
    .key_o    (key),
    .req_tgl_o(req_tgl),
    .ack_tgl_i(ack_tgl)
  );

  wdt_key_seq #(.KW(KW), .SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk_i    (wdt_clk_i),
    .rst_ni   (rst_ni),
    .req_tgl_i(req_tgl),
    .key_i    (key),
    .ack_tgl_o(ack_tgl),
    .enable_o (enable),
    .reload_o (reload)
  );

  wdt_counter #(.CNT_W(CNT_W), .RELOAD(RELOAD)) u_cnt (
    .clk_i    (wdt_clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable),
    .reload_i (reload),
    .rst_req_o(rst_req_o)
  );
endmodule

// File: tb/wdt_keyed_top_bench.sv
module wdt_keyed_top_bench;
  localparam int PERIOD = 256;  // 2^16 - 0xFF00
  localparam logic [7:0] CTRL = 8'h48;
  localparam logic [7:0] STAT = 8'h34;

  logic        clk = 1'b0;
  logic        wdt_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        rst_req;

  int tests = 0;
  int fails = 0;
  int npulse = 0;
  int cyc = 0;
  int last_cyc = 0;
  int last_gap = 0;
  int wide = 0;
  bit prev_req = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;      // 50 MHz bus clock
  always #15 wdt_clk = ~wdt_clk;

  wdt_keyed_top u_wdt_keyed_top (
    .clk_i(clk), .rst_ni(rst_n), .wdt_clk_i(wdt_clk),
    .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .rst_req_o(rst_req)
  );

  // pulse monitor in functional domain
  initial begin
    forever begin
      @(negedge wdt_clk);
      cyc++;
      if (rst_req) begin
        if (prev_req) wide++;
        if (npulse > 0) last_gap = cyc - last_cyc;
        last_cyc = cyc;
        npulse++;
      end
      prev_req = rst_req;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] v;
    n = 0;
    rd(STAT, v);
    while (v[4] && n < 40) begin
      @(negedge clk);
      n++;
      rd(STAT, v);
    end
  endtask

  task automatic key_pair(input logic [15:0] k1, input logic [15:0] k2);
    int n;
    wr(CTRL, {16'h0, k1});
    wait_idle(n);
    wr(CTRL, {16'h0, k2});
    wait_idle(n);
  endtask

  // returns 1 if a reset request appears within the window
  task automatic pulse_seen(input int window, output logic seen);
    int p0;
    p0 = npulse;
    repeat (window) @(negedge wdt_clk);
    seen = (npulse > p0);
  endtask

  // {first key, second key, expect enabled}
  localparam logic [32:0] VEC [7] = '{
    {16'hAAAA, 16'h1234, 1'b1},  // R4 wrong second key
    {16'h5555, 16'h5555, 1'b1},  // R5 second key alone
    {16'hAAAA, 16'h5555, 1'b0},  // R3 stop
    {16'hBBBB, 16'h5555, 1'b0},  // R4 wrong start second
    {16'h4444, 16'h4444, 1'b0},  // R5 start second alone
    {16'hBBBB, 16'h4444, 1'b1},  // R6 start
    {16'hAAAA, 16'h5555, 1'b0}   // R3 stop again
  };

  initial begin
    #5_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog timeout actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic seen;
    int n;

    repeat (3) @(negedge clk);
    rd(CTRL, v); check("R9 reset key readback", v, 32'h0);
    rd(STAT, v); check("R7 reset pending", v, 32'h0);
    check("R1 no request in reset", {31'h0, rst_req}, 32'h0);
    rst_n = 1'b1;

    // R1: default interval with no writes
    n = 0;
    while (npulse < 2 && n < 2000) begin @(negedge wdt_clk); n++; end
    check("R1 pulse interval", last_gap, PERIOD);

    // R7: pending set after write, clears within bound
    wr(CTRL, 32'h0000_1111);
    rd(STAT, v); check("R7 pending after write", v, 32'h10);
    wait_idle(n);
    check("R7 pending cleared in bound", {31'h0, (n < 40)}, 32'h1);
    rd(STAT, v); check("R7 pending clear", v, 32'h0);

    // vector table
    foreach (VEC[i]) begin
      key_pair(VEC[i][32:17], VEC[i][16:1]);
      rd(CTRL, v);
      check("R9 readback last key", v, {16'h0, VEC[i][16:1]});
      if (VEC[i][0]) pulse_seen(PERIOD + 16, seen);
      else           pulse_seen(2 * PERIOD, seen);
      check($sformatf("R3/R4/R5/R6 vec %0d enable", i), {31'h0, seen}, {31'h0, VEC[i][0]});
    end

    // R9: upper data bits are not stored
    key_pair(16'hBBBB, 16'h4444);
    wr(CTRL, 32'hFFFF_7777);
    wait_idle(n);
    rd(CTRL, v); check("R9 upper bits zero", v, 32'h0000_7777);

    // R10: unmapped / status writes ignored mid-sequence
    wr(CTRL, 32'h0000_AAAA);
    wait_idle(n);
    wr(8'h40, 32'h0000_5555);
    wr(STAT, 32'h0000_FFFF);
    rd(8'h40, v); check("R10 unmapped read", v, 32'h0);
    rd(STAT, v); check("R10 status write ignored", v, 32'h0);
    wr(CTRL, 32'h0000_5555);
    wait_idle(n);
    pulse_seen(2 * PERIOD, seen);
    check("R10 sequence survives ignored writes", {31'h0, seen}, 32'h0);

    // R8: write during pending dropped
    key_pair(16'hBBBB, 16'h4444);
    wr(CTRL, 32'h0000_AAAA);
    wr(CTRL, 32'h0000_1111);  // still pending
    rd(CTRL, v); check("R8 busy write dropped", v, 32'h0000_AAAA);
    wait_idle(n);
    wr(CTRL, 32'h0000_5555);
    wait_idle(n);
    pulse_seen(2 * PERIOD, seen);
    check("R8 sequencer untouched by dropped write", {31'h0, seen}, 32'h0);

    // R6: re-enable restores the full interval
    key_pair(16'hBBBB, 16'h4444);
    n = npulse;
    while (npulse < n + 2) @(negedge wdt_clk);
    check("R6 interval after re-enable", last_gap, PERIOD);

    check("R2 single-cycle requests", wide, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule